// File: doc/BRIEF.md
# Single-Channel Bus-Master Transfer Controller

This block copies a programmed number of bytes from a source to a destination without the processor's help. Either end may be memory or a peripheral. Before it drives the bus it asks the bus owner for the bus on `hold_req` and waits for `hold_ack`. Once it holds the bus it drives the address and the read and write strobes. A peripheral signals that it can take or give data on `dreq`.

There are two ways to move a byte. In a two-step transfer the byte is read into an internal holding register in one cycle and written out from that register in the next cycle. In a fly-by transfer both strobes are active in the same cycle, the memory side is addressed, and the data goes straight from source to destination. How long the controller keeps the bus is set by the retention mode:
- single: the bus is released after every byte.
- demand: the bus is kept while `dreq` stays high.
- block: the bus is kept until the whole count has been moved.

While the controller owns the bus it blocks interrupt acknowledge through `irq_inhibit`. The interface is plain control. The read and write strobes act as a one-cycle handshake with no back-pressure. A slow target holds the transfer off by keeping `dreq` or `hold_ack` low.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: A `start` is rejected when the count is zero, or when fly-by is requested with both ends in memory. A rejected start gives a one-cycle `cfg_err` pulse and no bus request, and the controller stays idle.
- R2: `rd_stb` and `wr_stb` are active only while both `hold_req` and `hold_ack` are high. Before the first grant, no strobe appears.
- R3: In a two-step transfer (`cfg_flyby`=0), each byte takes two cycles:
  - a read cycle with `rd_stb`=1 at the source address, in which `rd_data` is captured;
  - the next cycle, with `wr_stb`=1 at the destination address and `wr_data` equal to the captured byte.
- R4: In a fly-by transfer, each byte is one cycle with both strobes high. The address is the source address when the source is memory (`cfg_src_mem`=1), and the destination address otherwise.
- R5: Byte i of a transfer uses source address + i and destination address + i. Exactly `cfg_count` bytes are moved.
- R6: In single mode (`cfg_mode`=0), `hold_req` drops after every byte. It is raised again only after `hold_ack` has gone low.
- R7: In demand mode (`cfg_mode`=1), bytes continue back to back while `dreq` is high. If `dreq` is low at the end of a byte, the bus is released and no strobe occurs until `dreq` returns.
- R8: In block mode (`cfg_mode`=2 or 3), the bus is requested once and kept for the whole count, whatever `dreq` does after the grant.
- R9: `done` pulses for exactly one cycle after the last byte's strobe, and `hold_req` is already low in that cycle.
- R10: `irq_inhibit` is high whenever `hold_req` or `hold_ack` is high, and in particular during every strobe.
- R11: The bus is requested only after `dreq` is high, except for memory-to-memory transfers, which need no `dreq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer with the configuration inputs (taken only when idle) |
| cfg_src_addr | input | AW | First source address |
| cfg_dst_addr | input | AW | First destination address |
| cfg_count | input | CW | Number of bytes to move |
| cfg_mode | input | 2 | Retention mode: 0 single, 1 demand, 2/3 block |
| cfg_flyby | input | 1 | 1 = fly-by, 0 = two-step |
| cfg_src_mem | input | 1 | Source is memory |
| cfg_dst_mem | input | 1 | Destination is memory |
| dreq | input | 1 | Peripheral ready for a byte |
| hold_ack | input | 1 | Bus granted to the controller |
| rd_data | input | DW | Data returned by the source during a read strobe |
| hold_req | output | 1 | Bus request |
| bus_addr | output | AW | Address driven during strobes, zero otherwise |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| wr_data | output | DW | Holding register contents for two-step writes |
| irq_inhibit | output | 1 | Blocks interrupt acknowledge while the bus is owned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the count is exhausted |
| cfg_err | output | 1 | One-cycle pulse for a rejected start |

## Verification
The assertions check on every cycle the rules that relate the bus pins to each other:
- strobes happen only under an acknowledged request;
- a new request never rises while the old grant is still high;
- `done` is a single pulse with the bus released;
- an error pulse leaves the block idle;
- the interrupt block covers every strobe.

Other behaviour only shows over a whole transfer, so the directed scenarios cover it:
- address stepping and byte counts;
- data carried through the holding register;
- the memory-side address in fly-by;
- the number of bus releases for each retention mode;
- a demand-mode pause when `dreq` drops.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    XM_SINGLE = 2'd0,
    XM_DEMAND = 2'd1,
    XM_BLOCK  = 2'd2
  } xfer_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_REQ,
    S_RD,
    S_WR,
    S_FLY,
    S_REL
  } seq_state_e;
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic          last
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      dst <= '0;
      cnt <= '0;
    end else if (load) begin
      src <= cfg_src;
      dst <= cfg_dst;
      cnt <= cfg_cnt;
    end else if (step) begin
      src <= src + 1'b1;
      dst <= dst + 1'b1;
      cnt <= cnt - ONE;
    end
  end

  assign last = (cnt == ONE);
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cfg_ok,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_flyby,
  input  logic       cfg_src_mem,
  input  logic       cfg_dst_mem,
  input  logic       dreq,
  input  logic       hold_ack,
  input  logic       last,
  output seq_state_e st,
  output logic       load,
  output logic       step,
  output logic       hold_req,
  output logic       smem_q,
  output logic       done,
  output logic       err
);
  seq_state_e nxt;
  logic [1:0] mode_q;
  logic       fly_q, dmem_q, fin_q;
  logic       ready;
  seq_state_e xfer_st;

  assign ready   = (smem_q && dmem_q) || dreq;
  assign xfer_st = fly_q ? S_FLY : S_RD;

  always_comb begin
    nxt  = st;
    load = 1'b0;
    step = 1'b0;
    unique case (st)
      S_IDLE: if (start && cfg_ok) begin
        load = 1'b1;
        nxt  = S_ARM;
      end
      S_ARM: if (ready) nxt = S_REQ;
      S_REQ: if (hold_ack) nxt = xfer_st;
      S_RD:  nxt = S_WR;
      S_WR, S_FLY: begin
        step = 1'b1;
        if (last)                    nxt = S_REL;
        else if (mode_q == XM_SINGLE) nxt = S_REL;
        else if (mode_q == XM_DEMAND) nxt = dreq ? xfer_st : S_REL;
        else                         nxt = xfer_st;
      end
      S_REL: if (!hold_ack) nxt = fin_q ? S_IDLE : S_ARM;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode_q <= 2'd0;
      fly_q  <= 1'b0;
      smem_q <= 1'b0;
      dmem_q <= 1'b0;
      fin_q  <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      st   <= nxt;
      done <= step && last;
      err  <= (st == S_IDLE) && start && !cfg_ok;
      if (load) begin
        mode_q <= cfg_mode;
        fly_q  <= cfg_flyby;
        smem_q <= cfg_src_mem;
        dmem_q <= cfg_dst_mem;
        fin_q  <= 1'b0;
      end else if (step && last) begin
        fin_q <= 1'b1;
      end
    end
  end

  assign hold_req = (st == S_REQ) || (st == S_RD) || (st == S_WR) || (st == S_FLY);
endmodule

// File: rtl/dma_bus_drive.sv
module dma_bus_drive
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    st,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          smem_q,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data
);
  always_comb begin
    bus_addr = '0;
    rd_stb   = 1'b0;
    wr_stb   = 1'b0;
    unique case (st)
      S_RD: begin
        bus_addr = src;
        rd_stb   = 1'b1;
      end
      S_WR: begin
        bus_addr = dst;
        wr_stb   = 1'b1;
      end
      S_FLY: begin
        bus_addr = smem_q ? src : dst;
        rd_stb   = 1'b1;
        wr_stb   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wr_data <= '0;
    else if (st == S_RD) wr_data <= rd_data;
  end
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_flyby,
  input  logic          cfg_src_mem,
  input  logic          cfg_dst_mem,
  input  logic          dreq,
  input  logic          hold_ack,
  input  logic [DW-1:0] rd_data,
  output logic          hold_req,
  output logic [AW-1:0] bus_addr,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data,
  output logic          irq_inhibit,
  output logic          busy,
  output logic          done,
  output logic          cfg_err
);
  seq_state_e    st;
  logic          load, step, last, smem_q, cfg_ok;
  logic [AW-1:0] src, dst;

  assign cfg_ok = (cfg_count != '0) && !(cfg_flyby && cfg_src_mem && cfg_dst_mem);

  dma_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .cfg_src (cfg_src_addr),
    .cfg_dst (cfg_dst_addr),
    .cfg_cnt (cfg_count),
    .src     (src),
    .dst     (dst),
    .last    (last)
  );

  dma_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cfg_ok      (cfg_ok),
    .cfg_mode    (cfg_mode),
    .cfg_flyby   (cfg_flyby),
    .cfg_src_mem (cfg_src_mem),
    .cfg_dst_mem (cfg_dst_mem),
    .dreq        (dreq),
    .hold_ack    (hold_ack),
    .last        (last),
    .st          (st),
    .load        (load),
    .step        (step),
    .hold_req    (hold_req),
    .smem_q      (smem_q),
    .done        (done),
    .err         (cfg_err)
  );

  dma_bus_drive #(.AW(AW), .DW(DW)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .src      (src),
    .dst      (dst),
    .smem_q   (smem_q),
    .rd_data  (rd_data),
    .bus_addr (bus_addr),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data)
  );

  assign irq_inhibit = hold_req | hold_ack;
  assign busy        = (st != S_IDLE);
endmodule

// File: rtl/dma_xfer_ctrl_chk.sv
module dma_xfer_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_req,
  input logic hold_ack,
  input logic rd_stb,
  input logic wr_stb,
  input logic irq_inhibit,
  input logic busy,
  input logic done,
  input logic cfg_err
);
  // R2
  strobe_under_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> (hold_req && hold_ack));

  // R6
  rerequest_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req) |-> !hold_ack);

  // R9
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !hold_req && !rd_stb && !wr_stb);

  // R1
  reject_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy && !hold_req);

  // R10
  inhibit_covers_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> irq_inhibit);
endmodule

bind dma_xfer_ctrl dma_xfer_ctrl_chk u_chk (.*);

// File: tb/tb_dma_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_dma_xfer_ctrl;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int CW = 12;
  localparam logic [AW-1:0] SRC = 16'h0100;
  localparam logic [AW-1:0] DST = 16'h0240;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] cfg_src_addr = '0;
  logic [AW-1:0] cfg_dst_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [1:0]    cfg_mode = 2'd0;
  logic          cfg_flyby = 1'b0;
  logic          cfg_src_mem = 1'b0;
  logic          cfg_dst_mem = 1'b0;
  logic          dreq = 1'b0;
  logic          hold_ack;
  logic [DW-1:0] rd_data;
  logic          hold_req, rd_stb, wr_stb, irq_inhibit, busy, done, cfg_err;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] wr_data;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  dma_xfer_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut (.*);

  // bus owner: grant two cycles after request, drop one cycle after request drops
  logic ack_d;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_d    <= 1'b0;
      hold_ack <= 1'b0;
    end else begin
      ack_d    <= hold_req;
      hold_ack <= ack_d & hold_req;
    end
  end

  // memory/peripheral data model
  assign rd_data = bus_addr[7:0] ^ 8'h5A;

  // monitor
  logic [AW-1:0] wl_addr [64];
  logic [DW-1:0] wl_data [64];
  logic          wl_fly  [64];
  logic [AW-1:0] rl_addr [64];
  int wr_n = 0, rd_n = 0, rel_n = 0, rise_n = 0, done_n = 0, err_n = 0, bad_n = 0;
  logic req_prev = 1'b0;

  always @(negedge clk) begin
    if (wr_stb && wr_n < 64) begin
      wl_addr[wr_n] = bus_addr;
      wl_data[wr_n] = wr_data;
      wl_fly[wr_n]  = rd_stb;
    end
    if (wr_stb) wr_n++;
    if (rd_stb && !wr_stb && rd_n < 64) rl_addr[rd_n] = bus_addr;
    if (rd_stb && !wr_stb) rd_n++;
    if (req_prev && !hold_req) rel_n++;
    if (!req_prev && hold_req) rise_n++;
    if (done) done_n++;
    if (cfg_err) err_n++;
    if ((rd_stb || wr_stb) && !(hold_ack && irq_inhibit)) bad_n++;
    req_prev = hold_req;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go(input logic [CW-1:0] n, input logic [1:0] m, input logic fly,
                    input logic smem, input logic dmem);
    @(posedge clk); #1;
    cfg_src_addr = SRC; cfg_dst_addr = DST; cfg_count = n; cfg_mode = m;
    cfg_flyby = fly; cfg_src_mem = smem; cfg_dst_mem = dmem; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(input int base, input string req);
    int k = 0;
    while (done_n == base && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(done_n == base + 1, req, done_n - base, 1);
    repeat (6) @(negedge clk);
    chk(!busy && !hold_req, req, busy, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!hold_req, "R2", hold_req, 0);
    chk(!rd_stb && !wr_stb, "R2", {rd_stb, wr_stb}, 0);
    chk(!busy && !done, "R9", {busy, done}, 0);
    chk(!irq_inhibit, "R10", irq_inhibit, 0);
  endtask

  task automatic t_mem2mem_block();
    int w0 = wr_n, r0 = rd_n, l0 = rel_n, d0 = done_n;
    dreq = 1'b0;
    go(4, 2'd2, 1'b0, 1'b1, 1'b1);   // R11: no dreq needed
    wait_done(d0, "R9");
    chk(wr_n - w0 == 4, "R5", wr_n - w0, 4);
    chk(rd_n - r0 == 4, "R3", rd_n - r0, 4);
    for (int i = 0; i < 4; i++) begin
      chk(rl_addr[r0+i] == SRC + AW'(i), "R3", rl_addr[r0+i], SRC + AW'(i));
      chk(wl_addr[w0+i] == DST + AW'(i), "R5", wl_addr[w0+i], DST + AW'(i));
      chk(wl_data[w0+i] == (8'(SRC + AW'(i)) ^ 8'h5A), "R3", wl_data[w0+i],
          8'(SRC + AW'(i)) ^ 8'h5A);
      chk(!wl_fly[w0+i], "R3", wl_fly[w0+i], 0);
    end
    chk(rel_n - l0 == 1, "R8", rel_n - l0, 1);
  endtask

  task automatic t_reject();
    int e0 = err_n, s0 = rise_n;
    go(3, 2'd2, 1'b1, 1'b1, 1'b1);
    repeat (10) @(negedge clk);
    chk(err_n - e0 == 1, "R1", err_n - e0, 1);
    go(0, 2'd0, 1'b0, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk(err_n - e0 == 2, "R1", err_n - e0, 2);
    chk(rise_n == s0 && !busy, "R1", rise_n - s0, 0);
  endtask

  task automatic t_periph_wait();
    int s0 = rise_n, d0 = done_n;
    dreq = 1'b0;
    go(2, 2'd2, 1'b0, 1'b0, 1'b1);
    repeat (12) @(negedge clk);
    chk(rise_n == s0 && !hold_req, "R11", rise_n - s0, 0);
    @(posedge clk); #1; dreq = 1'b1;
    wait_done(d0, "R11");
    dreq = 1'b0;
  endtask

  task automatic t_single_flyby();
    int w0 = wr_n, l0 = rel_n, d0 = done_n;
    dreq = 1'b1;
    go(3, 2'd0, 1'b1, 1'b0, 1'b1);
    wait_done(d0, "R9");
    dreq = 1'b0;
    chk(wr_n - w0 == 3, "R5", wr_n - w0, 3);
    for (int i = 0; i < 3; i++) begin
      chk(wl_fly[w0+i], "R4", wl_fly[w0+i], 1);
      chk(wl_addr[w0+i] == DST + AW'(i), "R4", wl_addr[w0+i], DST + AW'(i));
    end
    chk(rel_n - l0 == 3, "R6", rel_n - l0, 3);
  endtask

  task automatic t_demand_pause();
    int w0 = wr_n, l0 = rel_n, d0 = done_n, snap, k = 0;
    dreq = 1'b1;
    go(6, 2'd1, 1'b0, 1'b1, 1'b0);
    while (wr_n - w0 < 2 && k < 2000) begin
      @(negedge clk);
      k++;
    end
    @(posedge clk); #1; dreq = 1'b0;
    repeat (8) @(negedge clk);
    snap = wr_n;
    repeat (15) @(negedge clk);
    chk(wr_n == snap && !hold_req, "R7", wr_n - snap, 0);
    @(posedge clk); #1; dreq = 1'b1;
    wait_done(d0, "R7");
    dreq = 1'b0;
    chk(wr_n - w0 == 6, "R7", wr_n - w0, 6);
    for (int i = 0; i < 6; i++)
      chk(wl_addr[w0+i] == DST + AW'(i), "R5", wl_addr[w0+i], DST + AW'(i));
    chk(rel_n - l0 >= 2, "R7", rel_n - l0, 2);
  endtask

  task automatic t_block_flyby_src_mem();
    int w0 = wr_n, l0 = rel_n, d0 = done_n, k = 0;
    dreq = 1'b1;
    go(5, 2'd2, 1'b1, 1'b1, 1'b0);
    while (!hold_req && k < 100) begin
      @(negedge clk);
      k++;
    end
    @(posedge clk); #1; dreq = 1'b0;   // R8: ignored once granted
    wait_done(d0, "R8");
    chk(wr_n - w0 == 5, "R8", wr_n - w0, 5);
    for (int i = 0; i < 5; i++)
      chk(wl_addr[w0+i] == SRC + AW'(i) && wl_fly[w0+i], "R4", wl_addr[w0+i], SRC + AW'(i));
    chk(rel_n - l0 == 1, "R8", rel_n - l0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    #1 rst_n = 1'b1;
    t_mem2mem_block();
    t_reject();
    t_periph_wait();
    t_single_flyby();
    t_demand_pause();
    t_block_flyby_src_mem();
    chk(bad_n == 0, "R2", bad_n, 0);
    chk(bad_n == 0, "R10", bad_n, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule